// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Periodic Timer

This block keeps time for a chip from a slow tick arriving at 32.768 kHz. It holds a 40-bit counter that steps once per slow tick (about 30.5 µs per step, roughly 388 days to wrap). Beside it sits a 40-bit alarm value that the counter is matched against. It also flags a warning well ahead of the counter wrapping. A separate 16-bit reloading down-counter runs from a faster tick of about 1.152 MHz and expires at most every ~56.9 ms. Both ticks arrive as single-cycle enables in the system clock domain.

Software reaches the block over a simple synchronous register port with eight word addresses. The 40-bit values are split into a low 32-bit word and a high byte. Reading the counter's low word freezes its high byte in a snapshot, so that a following read of the high word is coherent with the low word. The three interrupt sources each set a sticky status bit, which is cleared by writing 1. A per-source enable gates them onto one level interrupt output.

Top module: `rtc_timer_top`

## Requirements
- R1: After reset the counter, status, enables, timer reload and timer count are 0, the alarm is all ones, and `rdata` and `irq` are 0.
- R2: The counter adds one on every cycle with `slow_tick` high, holds on every other cycle, and wraps from all ones to zero.
- R3: A write to address 0 loads counter bits [31:0] from `wdata`, and a write to address 1 loads bits [39:32] from `wdata[7:0]`. A counter write in the same cycle as `slow_tick` wins, and that tick is lost.
- R4: A read of address 0 returns counter bits [31:0] and captures bits [39:32] in a snapshot. A read of address 1 returns that snapshot zero-extended, even if the counter has moved on since.
- R5: When a slow tick moves the counter onto the alarm value (low word at address 2, high byte at address 3), status bit 0 sets one cycle later.
- R6: When a slow tick moves the counter onto 0xFF_0000_0000 (upper 8 bits all ones, lower 32 zero), status bit 2 sets. This leaves 2^32 ticks before the wrap.
- R7: A write to address 4 sets the 16-bit reload and loads the timer count. On each `fast_tick` with a non-zero reload, a count of 1 or less is reloaded and status bit 1 sets; otherwise the count decrements. With a reload of 0 the timer stays at 0 and never expires. The count reads at address 7.
- R8: Status (address 5, bits [2:0]) is cleared bit by bit by writing 1. A source event in the same cycle as a clear leaves the bit set.
- R9: `irq` is high exactly when some status bit and its enable bit (address 6, bits [2:0]) are both 1. Enables never change status.
- R10: A read strobe returns the selected register on `rdata` in the next cycle, and `rdata` holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable at 32.768 kHz |
| fast_tick | input | 1 | One-cycle enable near 1.152 MHz |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined enabled interrupt level |

## Verification
The checker watches a set of rules on every cycle: the counter steps by exactly one or holds, each of the three internal events sets its status bit on the next edge, a set status bit survives unless it is written with 1, the timer count never exceeds its reload, and `irq` stays low while no status bit is set. Other behaviour is only seen across a sequence of register accesses, so the bench scenarios cover it. This includes the coherent snapshot on split reads, a counter write beating a simultaneous tick, a set beating a simultaneous clear, the reload-zero stop, and the exact tick on which the alarm and rollover warning land. The bench model also runs a long stretch of random ticks and accesses against the block cycle by cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int DATA_W = 32;
  localparam int NUM_SRC = 3;

  // interrupt source bit positions inside the status and enable words
  localparam int SRC_ALARM = 0;
  localparam int SRC_TIMER = 1;
  localparam int SRC_WRAP  = 2;

  typedef enum logic [2:0] {
    RA_CNT_LO  = 3'd0,
    RA_CNT_HI  = 3'd1,
    RA_ALM_LO  = 3'd2,
    RA_ALM_HI  = 3'd3,
    RA_RELOAD  = 3'd4,
    RA_STATUS  = 3'd5,
    RA_ENABLE  = 3'd6,
    RA_TMR_NOW = 3'd7
  } reg_addr_e;

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W     = 40,
  parameter int LO_W      = 32,
  parameter int WARN_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt_lo,
  input  logic             wr_cnt_hi,
  input  logic             wr_alm_lo,
  input  logic             wr_alm_hi,
  input  logic [LO_W-1:0]  wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] alarm,
  output logic             cnt_wr,
  output logic             alarm_evt,
  output logic             warn_evt
);
  localparam int HI_W = CNT_W - LO_W;

  function automatic logic [CNT_W-1:0] warn_point();
    return {{WARN_BITS{1'b1}}, {(CNT_W-WARN_BITS){1'b0}}};
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q, alarm_q, cnt_next;

  assign cnt_wr    = wr_cnt_lo | wr_cnt_hi;
  assign cnt_next  = step(cnt_q);
  assign alarm_evt = tick && !cnt_wr && (cnt_next == alarm_q);
  assign warn_evt  = tick && !cnt_wr && (cnt_next == warn_point());

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_q <= '1;
    end else begin
      if (cnt_wr) begin
        if (wr_cnt_lo) cnt_q[LO_W-1:0]     <= wdata;
        if (wr_cnt_hi) cnt_q[CNT_W-1:LO_W] <= wdata[HI_W-1:0];
      end else if (tick) begin
        cnt_q <= cnt_next;
      end
      if (wr_alm_lo) alarm_q[LO_W-1:0]     <= wdata;
      if (wr_alm_hi) alarm_q[CNT_W-1:LO_W] <= wdata[HI_W-1:0];
    end
  end

  assign cnt   = cnt_q;
  assign alarm = alarm_q;
endmodule

// File: rtl/rtc_period_timer.sv
module rtc_period_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic [TMR_W-1:0] reload,
  output logic [TMR_W-1:0] count,
  output logic             expire_evt
);
  function automatic logic at_end(input logic [TMR_W-1:0] c);
    return c <= TMR_W'(1);
  endfunction

  logic [TMR_W-1:0] reload_q, count_q;
  logic             running;

  assign running    = tick && !load && (reload_q != '0);
  assign expire_evt = running && at_end(count_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
    end else if (load) begin
      reload_q <= load_val;
      count_q  <= load_val;
    end else if (running) begin
      count_q <= at_end(count_q) ? reload_q : count_q - 1'b1;
    end
  end

  assign reload = reload_q;
  assign count  = count_q;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic         en_wr,
  input  logic [N-1:0] en_val,
  output logic [N-1:0] status,
  output logic [N-1:0] enable,
  output logic         irq
);
  logic [N-1:0] status_q, enable_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= evt[i] | (status_q[i] & ~clr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     enable_q <= '0;
    else if (en_wr) enable_q <= en_val;
  end

  assign status = status_q;
  assign enable = enable_q;
  assign irq    = |(status_q & enable_q);
endmodule

// File: rtl/rtc_timer_top.sv
module rtc_timer_top
  import rtc_pkg::*;
#(
  parameter int CNT_W     = 40,
  parameter int WARN_BITS = 8,
  parameter int TMR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int LO_W = DATA_W;
  localparam int HI_W = CNT_W - LO_W;

  reg_addr_e ra;
  assign ra = reg_addr_e'(addr);

  function automatic logic hit(input logic en, input reg_addr_e a, input reg_addr_e want);
    return en && (a == want);
  endfunction

  logic [CNT_W-1:0]   cnt, alarm;
  logic               cnt_wr, alarm_evt, warn_evt, tmr_evt;
  logic [TMR_W-1:0]   tmr_reload, tmr_count;
  logic [NUM_SRC-1:0] evt, clr_bits, status, enable;
  logic [HI_W-1:0]    snap_q;
  logic [DATA_W-1:0]  rdata_q;

  rtc_counter #(.CNT_W(CNT_W), .LO_W(LO_W), .WARN_BITS(WARN_BITS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (slow_tick),
    .wr_cnt_lo (hit(wr_en, ra, RA_CNT_LO)),
    .wr_cnt_hi (hit(wr_en, ra, RA_CNT_HI)),
    .wr_alm_lo (hit(wr_en, ra, RA_ALM_LO)),
    .wr_alm_hi (hit(wr_en, ra, RA_ALM_HI)),
    .wdata     (wdata),
    .cnt       (cnt),
    .alarm     (alarm),
    .cnt_wr    (cnt_wr),
    .alarm_evt (alarm_evt),
    .warn_evt  (warn_evt)
  );

  rtc_period_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (fast_tick),
    .load       (hit(wr_en, ra, RA_RELOAD)),
    .load_val   (wdata[TMR_W-1:0]),
    .reload     (tmr_reload),
    .count      (tmr_count),
    .expire_evt (tmr_evt)
  );

  always_comb begin
    evt = '0;
    evt[SRC_ALARM] = alarm_evt;
    evt[SRC_TIMER] = tmr_evt;
    evt[SRC_WRAP]  = warn_evt;
  end

  assign clr_bits = hit(wr_en, ra, RA_STATUS) ? wdata[NUM_SRC-1:0] : '0;

  rtc_irq_ctrl #(.N(NUM_SRC)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .clr    (clr_bits),
    .en_wr  (hit(wr_en, ra, RA_ENABLE)),
    .en_val (wdata[NUM_SRC-1:0]),
    .status (status),
    .enable (enable),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      snap_q  <= '0;
    end else if (rd_en) begin
      case (ra)
        RA_CNT_LO: begin
          rdata_q <= cnt[LO_W-1:0];
          snap_q  <= cnt[CNT_W-1:LO_W];
        end
        RA_CNT_HI:  rdata_q <= DATA_W'(snap_q);
        RA_ALM_LO:  rdata_q <= alarm[LO_W-1:0];
        RA_ALM_HI:  rdata_q <= DATA_W'(alarm[CNT_W-1:LO_W]);
        RA_RELOAD:  rdata_q <= DATA_W'(tmr_reload);
        RA_STATUS:  rdata_q <= DATA_W'(status);
        RA_ENABLE:  rdata_q <= DATA_W'(enable);
        RA_TMR_NOW: rdata_q <= DATA_W'(tmr_count);
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
  parameter int CNT_W = 40,
  parameter int TMR_W = 16,
  parameter int N     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slow_tick,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt,
  input logic             alarm_evt,
  input logic             warn_evt,
  input logic             tmr_evt,
  input logic [N-1:0]     status,
  input logic [N-1:0]     clr_bits,
  input logic [TMR_W-1:0] tmr_count,
  input logic [TMR_W-1:0] tmr_reload,
  input logic             irq
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick && !cnt_wr |=> cnt == $past(cnt) + 1'b1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick && !cnt_wr |=> $stable(cnt));

  p_alarm_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> status[0]);

  p_warn_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warn_evt |=> status[2]);

  p_timer_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt |=> status[1]);

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_count <= tmr_reload);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~$past(clr_bits)) & ~status) == '0));

  p_quiet_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status == '0 |-> !irq);
endmodule

bind rtc_timer_top rtc_checker #(.CNT_W(CNT_W), .TMR_W(TMR_W), .N(rtc_pkg::NUM_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slow_tick  (slow_tick),
  .cnt_wr     (cnt_wr),
  .cnt        (cnt),
  .alarm_evt  (alarm_evt),
  .warn_evt   (warn_evt),
  .tmr_evt    (tmr_evt),
  .status     (status),
  .clr_bits   (clr_bits),
  .tmr_count  (tmr_count),
  .tmr_reload (tmr_reload),
  .irq        (irq)
);

// File: tb/tb_rtc_timer_top.sv
module tb_rtc_timer_top;
  localparam longint MASK40 = 64'hFF_FFFF_FFFF;
  localparam longint WARNV  = 64'hFF_0000_0000;

  logic        clk = 0, rst_n = 0;
  logic        slow_tick = 0, fast_tick = 0, wr_en = 0, rd_en = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  rtc_timer_top dut (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  // behavioural reference model
  longint m_cnt, m_alm, m_snap, m_rd;
  int m_rel, m_tmr, m_st, m_en;
  bit m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_alm = MASK40; m_snap = 0; m_rd = 0;
      m_rel = 0; m_tmr = 0; m_st = 0; m_en = 0; m_irq = 0;
    end else begin
      int ev, clr;
      longint nxt;
      ev = 0; clr = 0;
      if (rd_en) begin
        case (addr)
          0: begin m_rd = m_cnt & 64'hFFFF_FFFF; m_snap = m_cnt >> 32; end
          1: m_rd = m_snap;
          2: m_rd = m_alm & 64'hFFFF_FFFF;
          3: m_rd = m_alm >> 32;
          4: m_rd = m_rel;
          5: m_rd = m_st;
          6: m_rd = m_en;
          default: m_rd = m_tmr;
        endcase
      end
      if (slow_tick && !(wr_en && addr <= 1)) begin
        nxt = (m_cnt + 1) & MASK40;
        if (nxt == m_alm) ev |= 1;
        if (nxt == WARNV) ev |= 4;
        m_cnt = nxt;
      end
      if (wr_en && addr == 4) begin
        m_rel = wdata & 32'hFFFF; m_tmr = m_rel;
      end else if (fast_tick && m_rel != 0) begin
        if (m_tmr <= 1) begin m_tmr = m_rel; ev |= 2; end
        else m_tmr = m_tmr - 1;
      end
      if (wr_en) begin
        case (addr)
          0: m_cnt = (m_cnt & 64'hFF_0000_0000) | longint'(wdata);
          1: m_cnt = (m_cnt & 64'hFFFF_FFFF) | (longint'(wdata & 32'hFF) << 32);
          2: m_alm = (m_alm & 64'hFF_0000_0000) | longint'(wdata);
          3: m_alm = (m_alm & 64'hFFFF_FFFF) | (longint'(wdata & 32'hFF) << 32);
          5: clr = wdata & 7;
          6: m_en = wdata & 7;
          default: ;
        endcase
      end
      m_st  = (m_st & ~clr) | ev;
      m_irq = (m_st & m_en) != 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks += 2;
      if (longint'(rdata) != m_rd) begin
        n_fail++; $display("FAIL R10 model rdata got %h exp %h", rdata, m_rd);
      end
      if (irq !== m_irq) begin
        n_fail++; $display("FAIL R9 model irq got %0d exp %0d", irq, m_irq);
      end
    end
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    n_checks++;
    if (got != exp) begin
      n_fail++; $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus(input bit w, input bit r, input int a, input longint d,
                     input bit st, input bit ft);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = 3'(a); wdata = 32'(d); slow_tick = st; fast_tick = ft;
    @(negedge clk);
    wr_en = 0; rd_en = 0; slow_tick = 0; fast_tick = 0;
  endtask

  task automatic wr(input int a, input longint d); bus(1, 0, a, d, 0, 0); endtask

  task automatic rd(input int a, output longint v);
    bus(0, 1, a, 0, 0, 0); v = longint'(rdata);
  endtask

  task automatic slow(input int n); repeat (n) bus(0, 0, 0, 0, 1, 0); endtask
  task automatic fast(input int n); repeat (n) bus(0, 0, 0, 0, 0, 1); endtask

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    longint v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", longint'(rdata), 0);
    chk("R1 irq", longint'(irq), 0);
    rd(0, v); chk("R1 cnt lo", v, 0);
    rd(3, v); chk("R1 alarm hi", v, 64'hFF);
    rd(2, v); chk("R1 alarm lo", v, 64'hFFFF_FFFF);
    rd(4, v); chk("R1 reload", v, 0);
    rd(5, v); chk("R1 status", v, 0);

    // R2 carry across words, R6 warning on crossing
    wr(0, 64'hFFFF_FFFE); wr(1, 64'hFE);
    slow(3);
    rd(0, v); chk("R2 lo after carry", v, 1);
    rd(1, v); chk("R2 hi after carry", v, 64'hFF);
    rd(5, v); chk("R6 warn status", v, 4);

    // R4 coherent split read
    wr(1, 64'h12); wr(0, 64'hFFFF_FFFF);
    rd(0, v); chk("R4 lo", v, 64'hFFFF_FFFF);
    slow(1);
    rd(1, v); chk("R4 snapshot hi", v, 64'h12);
    rd(0, v); chk("R4 lo new", v, 0);
    rd(1, v); chk("R4 hi new", v, 64'h13);

    // R3 write beats tick
    bus(1, 0, 0, 64'h55, 1, 0);
    wr(1, 0);
    rd(0, v); chk("R3 write priority", v, 64'h55);

    // R8 clear
    wr(5, 7);
    rd(5, v); chk("R8 cleared", v, 0);

    // R5 alarm
    wr(3, 0); wr(2, 64'h58);
    slow(2);
    rd(5, v); chk("R5 before match", v, 0);
    slow(1);
    rd(5, v); chk("R5 on match", v, 1);
    chk("R9 masked", longint'(irq), 0);
    wr(6, 1); chk("R9 enabled", longint'(irq), 1);
    wr(6, 2); chk("R9 other enable", longint'(irq), 0);
    rd(5, v); chk("R9 enable keeps status", v, 1);
    wr(6, 1); wr(5, 1);
    chk("R8 irq after clear", longint'(irq), 0);
    rd(5, v); chk("R8 status after clear", v, 0);
    // set wins over clear
    wr(2, 64'h5A);
    slow(1);
    bus(1, 0, 5, 1, 1, 0);
    rd(5, v); chk("R8 set beats clear", v, 1);
    wr(5, 7); wr(6, 0);

    // R7 periodic timer
    wr(4, 3);
    rd(7, v); chk("R7 loaded", v, 3);
    fast(2);
    rd(7, v); chk("R7 decrement", v, 1);
    rd(5, v); chk("R7 not yet", v, 0);
    fast(1);
    rd(7, v); chk("R7 reloaded", v, 3);
    rd(5, v); chk("R7 expired", v, 2);
    wr(4, 0); wr(5, 7);
    fast(4);
    rd(7, v); chk("R7 stopped count", v, 0);
    rd(5, v); chk("R7 stopped status", v, 0);

    // R2 wrap and hold
    wr(1, 64'hFF); wr(0, 64'hFFFF_FFFF);
    wr(5, 7);
    slow(1);
    rd(0, v); chk("R2 wrap lo", v, 0);
    rd(1, v); chk("R2 wrap hi", v, 0);
    repeat (5) @(negedge clk);
    rd(0, v); chk("R2 hold", v, 0);

    // R10 read data held without a read
    wr(4, 9);
    rd(4, v); chk("R10 read", v, 9);
    wr(4, 5);
    repeat (2) @(negedge clk);
    chk("R10 held", longint'(rdata), 9);

    // random traffic against the model
    wr(0, 64'hFFFF_FFC0); wr(1, 64'hFE); wr(6, 7); wr(4, 6);
    for (int i = 0; i < 4000; i++) begin
      int a;
      longint d;
      a = $urandom % 8;
      case (a)
        0: d = 64'hFFFF_FF00 + ($urandom % 256);
        1: d = 64'hFE + ($urandom % 2);
        2: d = 64'hFFFF_FF00 + ($urandom % 256);
        4: d = $urandom % 12;
        default: d = $urandom;
      endcase
      @(negedge clk);
      slow_tick = ($urandom % 3) == 0;
      fast_tick = ($urandom % 2) == 0;
      wr_en = ($urandom % 8) == 0;
      rd_en = ($urandom % 2) == 0;
      addr = 3'(a); wdata = 32'(d);
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0; slow_tick = 0; fast_tick = 0;
    @(negedge clk);
    summary();
  end
endmodule